// File: doc/BRIEF.md
# Vector Floating-Point Narrowing Converter

This block turns a 128-bit vector of floating-point values into a 64-bit vector of values at half the width. A size select picks one of two arrangements. In the first, four single-precision lanes become four half-precision lanes. In the second, two double-precision lanes become two single-precision lanes. Every lane is rounded to the IEEE 754 target format under a 2-bit rounding-mode input. Each lane reports the exceptions it raises, and the lane flags are ORed into one 4-bit status output.

The 64-bit narrowed vector is placed in a destination in one of two ways. With the low placement, it fills bits [63:0] and bits [127:64] are forced to zero. With the high placement, it fills bits [127:64] and bits [63:0] keep the previous destination low half, which arrives on its own input. All outputs are registered, so a result appears one cycle after its input strobe.

Top module: `vfn_top`

## Requirements
- R1: When `wide_sel`=0, each 32-bit source lane i (bits [32i+31:32i], i=0..3) converts to 16-bit result lane i. When `wide_sel`=1, each 64-bit source lane i (i=0..1) converts to 32-bit result lane i. Lane 0 is the least significant lane.
- R2: When `hi_sel`=0, the narrowed vector goes to `dst_new[63:0]` and `dst_new[127:64]` is zero.
- R3: When `hi_sel`=1, the narrowed vector goes to `dst_new[127:64]` and `dst_new[63:0]` equals `dst_lo_old` as sampled with the strobe.
- R4: `rnd_mode` codes are 00 nearest-even, 01 toward +infinity, 10 toward -infinity, 11 toward zero, and each finite result is rounded correctly in that mode.
- R5: When the rounded magnitude exceeds the target's largest finite value, the result is infinity under nearest-even, or when the mode rounds away from zero for that sign. Otherwise it is the largest finite value of that sign. Overflow (flag bit 1) and inexact (flag bit 3) are both set.
- R6: A value below the smallest normal magnitude, judged before rounding, gives a correctly rounded subnormal, a zero or the smallest normal. If it is also inexact, it sets underflow (flag bit 2).
- R7: Any loss of precision in rounding sets inexact (flag bit 3). An exact conversion sets no flag.
- R8: A NaN input gives a NaN with the same sign, the quiet bit set, and the source payload bits just below the quiet bit kept in the remaining result payload. A signalling NaN (quiet bit 0) also sets invalid (flag bit 0). Infinities and zeros keep their sign and raise no flag.
- R9: `exc_flags` is the OR of the flags of all lanes in the selected arrangement, with bit 0 invalid, bit 1 overflow, bit 2 underflow and bit 3 inexact.
- R10: `out_valid` is `in_valid` delayed by one clock. `dst_new` and `exc_flags` change only in the cycle after a strobe and otherwise hold.
- R11: While `rst_n` is low, `out_valid`, `dst_new` and `exc_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| wide_sel | input | 1 | 0: 32-to-16 lanes, 1: 64-to-32 lanes |
| hi_sel | input | 1 | 0: low placement, 1: high placement |
| rnd_mode | input | 2 | Rounding-mode code |
| src_vec | input | 128 | Source vector |
| dst_lo_old | input | 64 | Previous destination low half |
| out_valid | output | 1 | Result strobe |
| dst_new | output | 128 | Merged destination value |
| exc_flags | output | 4 | ORed exception flags |

## Verification
The bench builds the block with the default 128-bit vector width. At that width both lane arrangements exist at once: four half-precision lanes and two single-precision lanes. The bench exercises both placements under every rounding mode. Its random values cluster near the overflow threshold and the subnormal boundary of each target format, so ties, carries into the exponent and rounding up into the smallest normal all occur. Directed vectors add NaNs, infinities and signed zeros, and mix lanes that raise different flags in one operation.

// File: rtl/vfn_pkg.sv
package vfn_pkg;
  localparam int FLG_INV = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_INX = 3;
  localparam int FLG_W   = 4;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_POS  = 2'b01,
    RM_NEG  = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/vfn_lane.sv
module vfn_lane #(
  parameter int SRC_EXP = 8,
  parameter int SRC_MAN = 23,
  parameter int DST_EXP = 5,
  parameter int DST_MAN = 10
) (
  input  logic [SRC_EXP+SRC_MAN:0] src_i,
  input  logic [1:0]               rm_i,
  output logic [DST_EXP+DST_MAN:0] res_o,
  output logic [3:0]               flags_o
);
  import vfn_pkg::*;

  localparam int S        = SRC_MAN + 1;
  localparam int K        = DST_MAN + 1;
  localparam int D        = SRC_MAN - DST_MAN;
  localparam int EW       = SRC_EXP + 2;
  localparam int SHW      = $clog2(S + 1) + 1;
  localparam int BIAS_GAP = (2 ** (SRC_EXP - 1)) - (2 ** (DST_EXP - 1));
  localparam int DEMAX    = (2 ** DST_EXP) - 1;

  // Rounding increment decision for one lane
  function automatic logic round_up(input logic [1:0] rm, input logic sgn,
                                    input logic lsb, input logic grd, input logic stk);
    case (rm)
      RM_NEAR: return grd & (stk | lsb);
      RM_POS:  return ~sgn & (grd | stk);
      RM_NEG:  return sgn & (grd | stk);
      default: return 1'b0;
    endcase
  endfunction

  // Saturated result on overflow: infinity or largest finite
  function automatic logic [DST_EXP+DST_MAN:0] ovf_value(input logic [1:0] rm, input logic sgn);
    logic away;
    away = (rm == RM_NEAR) || (rm == RM_POS && !sgn) || (rm == RM_NEG && sgn);
    if (away) return {sgn, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
    return {sgn, {(DST_EXP-1){1'b1}}, 1'b0, {DST_MAN{1'b1}}};
  endfunction

  logic                 sgn;
  logic [SRC_EXP-1:0]   ef;
  logic [SRC_MAN-1:0]   mf;
  logic [S-1:0]         sig, shifted;
  logic signed [EW-1:0] de_s, shn, exp_n;
  logic [SHW-1:0]       sh;
  logic                 tiny, lost, grd, stk, inc, inexact;
  logic [K-1:0]         kept;
  logic [K:0]           rnd;

  always_comb begin
    sgn  = src_i[SRC_EXP+SRC_MAN];
    ef   = src_i[SRC_MAN +: SRC_EXP];
    mf   = src_i[SRC_MAN-1:0];
    sig  = {|ef, mf};
    de_s = $signed({2'b00, ef | {{(SRC_EXP-1){1'b0}}, ~|ef}}) - EW'(BIAS_GAP);
    tiny = (de_s <= 0);
    shn  = EW'(1) - de_s;
    if (!tiny)               sh = '0;
    else if (shn > EW'(S))   sh = SHW'(S);
    else                     sh = SHW'(shn);
    shifted = sig >> sh;
    lost    = |(sig & ~({S{1'b1}} << sh));
    kept    = shifted[S-1 -: K];
    grd     = shifted[D-1];
    stk     = (|shifted[D-2:0]) | lost;
    inexact = grd | stk;
    inc     = round_up(rm_i, sgn, kept[0], grd, stk);
    rnd     = {1'b0, kept} + {{K{1'b0}}, inc};
    exp_n   = de_s + $signed({{(EW-1){1'b0}}, rnd[K]});

    flags_o = '0;
    if (&ef) begin
      if (|mf) begin
        res_o = {sgn, {DST_EXP{1'b1}}, 1'b1, mf[SRC_MAN-2 -: DST_MAN-1]};
        flags_o[FLG_INV] = ~mf[SRC_MAN-1];
      end else begin
        res_o = {sgn, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
      end
    end else if (tiny) begin
      res_o = {sgn, {(DST_EXP-1){1'b0}}, rnd[K-1:0]};
      flags_o[FLG_INX] = inexact;
      flags_o[FLG_UNF] = inexact;
    end else if (exp_n >= EW'(DEMAX)) begin
      res_o = ovf_value(rm_i, sgn);
      flags_o[FLG_OVF] = 1'b1;
      flags_o[FLG_INX] = 1'b1;
    end else begin
      res_o = {sgn, exp_n[DST_EXP-1:0], rnd[K-2:0]};
      flags_o[FLG_INX] = inexact;
    end
  end
endmodule

// File: rtl/vfn_merge.sv
module vfn_merge #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0]   narrow_i,
  input  logic [HALF_W-1:0]   old_lo_i,
  input  logic                hi_i,
  output logic [2*HALF_W-1:0] merged_o
);
  always_comb begin
    if (hi_i) merged_o = {narrow_i, old_lo_i};
    else      merged_o = {{HALF_W{1'b0}}, narrow_i};
  end
endmodule

// File: rtl/vfn_top.sv
module vfn_top #(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 wide_sel,
  input  logic                 hi_sel,
  input  logic [1:0]           rnd_mode,
  input  logic [VEC_W-1:0]     src_vec,
  input  logic [VEC_W/2-1:0]   dst_lo_old,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     dst_new,
  output logic [3:0]           exc_flags
);
  import vfn_pkg::*;

  localparam int HALF_W = VEC_W / 2;
  localparam int N_H    = HALF_W / 16;
  localparam int N_S    = HALF_W / 32;

  logic [HALF_W-1:0] nar_h, nar_s, nar_sel;
  logic [FLG_W-1:0]  flg_h [N_H];
  logic [FLG_W-1:0]  flg_s [N_S];
  logic [FLG_W-1:0]  flg_h_or, flg_s_or, flg_sel;
  logic [VEC_W-1:0]  merged;

  for (genvar i = 0; i < N_H; i++) begin : g_half
    vfn_lane #(.SRC_EXP(8), .SRC_MAN(23), .DST_EXP(5), .DST_MAN(10)) u_lane (
      .src_i(src_vec[i*32 +: 32]), .rm_i(rnd_mode),
      .res_o(nar_h[i*16 +: 16]), .flags_o(flg_h[i]));
  end

  for (genvar i = 0; i < N_S; i++) begin : g_single
    vfn_lane #(.SRC_EXP(11), .SRC_MAN(52), .DST_EXP(8), .DST_MAN(23)) u_lane (
      .src_i(src_vec[i*64 +: 64]), .rm_i(rnd_mode),
      .res_o(nar_s[i*32 +: 32]), .flags_o(flg_s[i]));
  end

  always_comb begin
    flg_h_or = '0;
    for (int i = 0; i < N_H; i++) flg_h_or |= flg_h[i];
    flg_s_or = '0;
    for (int i = 0; i < N_S; i++) flg_s_or |= flg_s[i];
    nar_sel = wide_sel ? nar_s : nar_h;
    flg_sel = wide_sel ? flg_s_or : flg_h_or;
  end

  vfn_merge #(.HALF_W(HALF_W)) u_merge (
    .narrow_i(nar_sel), .old_lo_i(dst_lo_old), .hi_i(hi_sel), .merged_o(merged));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_new   <= '0;
      exc_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_new   <= merged;
        exc_flags <= flg_sel;
      end
    end
  end
endmodule

// File: rtl/vfn_checker.sv
module vfn_checker #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               hi_sel,
  input logic [VEC_W/2-1:0] dst_lo_old,
  input logic               out_valid,
  input logic [VEC_W-1:0]   dst_new,
  input logic [3:0]         exc_flags
);
  localparam int HW = VEC_W / 2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst_new) && $stable(exc_flags))); // R10
  AST_LOW_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hi_sel) |=> (dst_new[VEC_W-1:HW] == '0)); // R2
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hi_sel) |=> (dst_new[HW-1:0] == $past(dst_lo_old))); // R3
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[1]) |-> exc_flags[3]); // R5
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_flags[2]) |-> exc_flags[3]); // R6
endmodule

bind vfn_top vfn_checker #(.VEC_W(VEC_W)) u_vfn_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hi_sel(hi_sel),
  .dst_lo_old(dst_lo_old), .out_valid(out_valid), .dst_new(dst_new),
  .exc_flags(exc_flags));

// File: tb/test_vfn_top.sv
`timescale 1ns/1ps
module test_vfn_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, wide_sel = 1'b0, hi_sel = 1'b0;
  logic [1:0]   rnd_mode = 2'b00;
  logic [127:0] src_vec = '0;
  logic [63:0]  dst_lo_old = '0;
  logic         out_valid;
  logic [127:0] dst_new;
  logic [3:0]   exc_flags;
  int checks = 0, errors = 0;
  logic [127:0] last_dst;
  logic [3:0]   last_flg;

  always #4 clk = ~clk;

  vfn_top i_vfn_top (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
    .hi_sel(hi_sel), .rnd_mode(rnd_mode), .src_vec(src_vec), .dst_lo_old(dst_lo_old),
    .out_valid(out_valid), .dst_new(dst_new), .exc_flags(exc_flags));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: remainder-versus-half rounding on an integer significand
  function automatic void ref_cvt(input logic [63:0] x, input bit wide, input logic [1:0] rm,
                                  output logic [31:0] r, output logic [3:0] f);
    int se, sm, dex, dm, sb, db, ef, xe, p, vexp, emin, qexp, sh, expb;
    longint unsigned one, mf, m, keep, rem, half, acc;
    bit sgn, inx, above, tie, inc, away;
    se = wide ? 11 : 8;  sm = wide ? 52 : 23;
    dex = wide ? 8 : 5;  dm = wide ? 23 : 10;
    sb = (1 << (se - 1)) - 1;  db = (1 << (dex - 1)) - 1;
    one = 1;  f = '0;
    sgn = x[se + sm];
    ef = int'((x >> sm) & ((one << se) - 1));
    mf = x & ((one << sm) - 1);
    acc = longint'(sgn) << (dex + dm);
    if (ef == (1 << se) - 1) begin
      acc |= ((one << dex) - 1) << dm;
      if (mf != 0) begin
        acc |= (one << (dm - 1)) | ((mf >> (sm - dm)) & ((one << (dm - 1)) - 1));
        if (mf[sm - 1] == 1'b0) f[0] = 1'b1;
      end
    end else if (!(ef == 0 && mf == 0)) begin
      m = (ef == 0) ? mf : (mf | (one << sm));
      xe = ((ef == 0) ? 1 : ef) - sb - sm;
      p = 0;
      for (int i = 0; i < 64; i++) if (m[i]) p = i;
      vexp = xe + p;  emin = 1 - db;
      qexp = ((vexp < emin) ? emin : vexp) - dm;
      sh = qexp - xe;
      if (sh >= 64) begin
        keep = 0; inx = (m != 0); above = 1'b0; tie = 1'b0;
      end else begin
        keep = m >> sh;  rem = m & ((one << sh) - 1);  half = one << (sh - 1);
        inx = (rem != 0); above = (rem > half); tie = (rem == half);
      end
      case (rm)
        2'b00: inc = above || (tie && keep[0]);
        2'b01: inc = inx && !sgn;
        2'b10: inc = inx && sgn;
        default: inc = 1'b0;
      endcase
      keep += longint'(inc);
      if (keep == (one << (dm + 1))) begin keep = keep >> 1; qexp++; end
      if (inx) f[3] = 1'b1;
      if (inx && vexp < emin) f[2] = 1'b1;
      expb = (keep < (one << dm)) ? 0 : qexp + dm + db;
      if (expb >= (1 << dex) - 1) begin
        f[1] = 1'b1; f[3] = 1'b1;
        away = (rm == 2'b00) || (rm == 2'b01 && !sgn) || (rm == 2'b10 && sgn);
        if (away) acc |= ((one << dex) - 1) << dm;
        else      acc |= (((one << dex) - 2) << dm) | ((one << dm) - 1);
      end else begin
        acc |= (longint'(expb) << dm) | (keep & ((one << dm) - 1));
      end
    end
    r = acc[31:0];
  endfunction

  task automatic do_op(input logic [127:0] src, input logic [63:0] old, input bit wide,
                       input bit hi, input logic [1:0] rm, input string req);
    logic [63:0] nar;
    logic [3:0] fexp, fl;
    logic [31:0] r;
    logic [127:0] dexp, hold;
    int ew;
    nar = '0; fexp = '0;
    ew = wide ? 32 : 16;
    for (int e = 0; e < (wide ? 2 : 4); e++) begin
      if (wide) ref_cvt(src[e*64 +: 64], 1'b1, rm, r, fl);
      else      ref_cvt({32'b0, src[e*32 +: 32]}, 1'b0, rm, r, fl);
      nar |= (64'(r) & ((64'd1 << ew) - 1)) << (e * ew);
      fexp |= fl;
    end
    dexp = hi ? {nar, old} : {64'b0, nar};
    @(negedge clk);
    src_vec = src; dst_lo_old = old; wide_sel = wide; hi_sel = hi; rnd_mode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R10 valid"}, 128'(out_valid), 128'd1);
    chk({req, " R1/R2/R3/R4 data"}, dst_new, dexp);
    chk({req, " R9 flags"}, 128'(exc_flags), 128'(fexp));
    last_dst = dst_new; last_flg = exc_flags; hold = dst_new;
    src_vec = ~src; dst_lo_old = ~old; hi_sel = ~hi;
    @(negedge clk);
    chk("R10 idle valid", 128'(out_valid), 128'd0);
    chk("R10 idle hold", {dst_new[123:0], exc_flags}, {hold[123:0], fexp});
  endtask

  function automatic logic [63:0] gen_f64();
    logic [10:0] e;
    case ($urandom % 4)
      0: return {$urandom, $urandom};
      1: e = 11'(1023 - 140 + $urandom % 281);
      2: e = 11'(1023 - 126 - 26 + $urandom % 30);
      default: e = 11'(1023 + 124 + $urandom % 6);
    endcase
    return {1'($urandom), e, 20'($urandom), $urandom};
  endfunction

  function automatic logic [31:0] gen_f32();
    logic [7:0] e;
    case ($urandom % 4)
      0: return $urandom;
      1: e = 8'(127 - 20 + $urandom % 41);
      2: e = 8'(127 - 14 - 13 + $urandom % 16);
      default: e = 8'(127 + 13 + $urandom % 6);
    endcase
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R11 reset", {dst_new[122:0], exc_flags, out_valid}, 128'd0);
    rst_n = 1'b1;
    // Directed half-precision corners: 1.0, sNaN, 2^-25 tie, 65520 overflow
    do_op({64'h0, 32'h477FF000, 32'h33000000, 32'h7F800001, 32'h3F800000},
          64'h0123456789ABCDEF, 1'b0, 1'b0, 2'b00, "R5/R6/R8");
    chk("R9 hand lanes", last_dst, {64'h0, 16'h7C00, 16'h0000, 16'h7E00, 16'h3C00});
    chk("R9 hand flags", 128'(last_flg), 128'hF);
    do_op({64'h0, 32'h477FF000, 32'h33000000, 32'hFF800000, 32'h80000000},
          64'hFEDCBA9876543210, 1'b0, 1'b1, 2'b11, "R5/R8");
    chk("R3 hand high", last_dst, {16'h7BFF, 16'h0000, 16'hFC00, 16'h8000, 64'hFEDCBA9876543210});
    do_op({64'h0, 32'h33000000, 32'hB3000001, 32'h387FE000, 32'h7FC12345},
          64'h0, 1'b0, 1'b0, 2'b01, "R4/R6/R8");
    do_op({64'h7FE0000000000000, 64'h3FF0000000000000}, 64'h5A5A, 1'b1, 1'b0, 2'b10, "R5/R7");
    chk("R5 hand wide", last_dst, {64'h0, 32'h7F7FFFFF, 32'h3F800000});
    do_op({64'hFFE0000000000000, 64'h7FF4000000000001}, 64'hA5A5, 1'b1, 1'b1, 2'b01, "R5/R8");
    chk("R8 hand wide", last_dst, {32'hFF7FFFFF, 32'h7FE00000, 64'hA5A5});
    do_op({64'h0000000000000001, 64'h36A0000000000000}, 64'h0, 1'b1, 1'b0, 2'b00, "R6");
    do_op({64'h3FF0000010000000, 64'h3FF0000030000000}, 64'h0, 1'b1, 1'b0, 2'b00, "R4/R7");
    for (int n = 0; n < 400; n++) begin
      bit wide;
      logic [127:0] s;
      wide = 1'($urandom);
      if (wide) s = {gen_f64(), gen_f64()};
      else      s = {gen_f32(), gen_f32(), gen_f32(), gen_f32()};
      do_op(s, {$urandom, $urandom}, wide, 1'($urandom), 2'($urandom), "R1/R4/R6/R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule